// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This unit gathers the eleven interrupt causes of a serial port into one latched status word. The causes are four modem-line changes, a receive-level event, a transmit-level event, a receive timeout and four receive errors. Software can see the latched status, a copy of it filtered through an enable mask, and a single interrupt line that is the OR of the filtered copy. A write-one-to-clear strobe removes latched causes.

Modem-change, timeout and error causes arrive as one-cycle pulses from neighbouring logic. The receive and transmit level causes are derived inside the unit. It compares the FIFO occupancy counts it is given against thresholds chosen through a level-select register, in eighths of the FIFO depth. When the FIFOs are switched off, the comparison falls back to single-character behaviour.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Each cause owns a fixed status bit. Bit 0 is ring indicator, 1 CTS change, 2 DCD change and 3 DSR change, taken from `modem_evt[0..3]`. Bit 4 is receive level and bit 5 transmit level. Bit 6 is receive timeout. Bits 7 to 10 are framing, parity, break and overrun, taken from `err_evt[0..3]`. A pulse on an input sets its bit at the next clock edge.
- R2: A set status bit stays set until software clears it.
- R3: A clear strobe with data word W clears every status bit where W holds a one and leaves the rest. W = 0x7FF clears all eleven bits.
- R4: If a cause is raised in the same cycle that a clear names its bit, the bit ends up set.
- R5: The mask register loads `mask_wdata` on `mask_wr`. The masked status equals raw status AND mask. `irq` is high exactly when some masked bit is one.
- R6: The level-select register loads `lvl_wdata` on `lvl_wr`. Bits [2:0] hold the transmit code and bits [5:3] the receive code. Codes 0, 1, 2, 3 and 4 stand for 1/8, 1/4, 1/2, 3/4 and 7/8 of FIFO depth.
- R7: With FIFOs on, bit 4 is set one cycle after `rx_count` first becomes greater than or equal to the receive threshold.
- R8: With FIFOs on, bit 5 is set one cycle after `tx_count` first becomes less than or equal to the transmit threshold.
- R9: Level codes 5, 6 and 7 act as 1/2 of FIFO depth.
- R10: With FIFOs off, bit 4 sets when `rx_count` first becomes nonzero and bit 5 sets when `tx_count` first reaches zero.
- R11: Reset clears the raw status, the mask and the level-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled; selects the threshold comparison |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 11 | New mask value |
| clr_wr | input | 1 | Clear strobe |
| clr_wdata | input | 11 | Ones select status bits to clear |
| lvl_wr | input | 1 | Write strobe for the level-select register |
| lvl_wdata | input | 6 | New level codes, receive [5:3], transmit [2:0] |
| modem_evt | input | 4 | Modem-line change pulses (ring, CTS, DCD, DSR) |
| rx_tmo_evt | input | 1 | Receive timeout pulse |
| err_evt | input | 4 | Receive error pulses (framing, parity, break, overrun) |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| mask_q | output | 11 | Mask register contents |
| lvl_sel | output | 6 | Level-select register contents |
| raw_status | output | 11 | Latched causes before masking |
| masked_status | output | 11 | Latched causes after masking |
| irq | output | 1 | Combined interrupt |

## Verification
A new cause and a software clear of the same bit can fall in one cycle. The bench provokes this on purpose: it raises a framing-error pulse while strobing a clear of 0x7FF in the same cycle. The expected result is the framing bit alone surviving. A reference model, which updates the set after the clear, judges this case. It also judges random traffic in which clears, mask writes, level writes and events overlap freely. Threshold crossings in both FIFO modes and with the out-of-range level codes are driven as directed sequences.

// File: rtl/uart_irq_pkg.sv
// Shared definitions for the UART interrupt unit.
// Assumes eleven causes with fixed bit positions.
package uart_irq_pkg;

    localparam int NUM_SRC = 11;

    // Status bit positions; software decodes these.
    typedef enum int unsigned {
        SRC_RING    = 0,
        SRC_CTS     = 1,
        SRC_DCD     = 2,
        SRC_DSR     = 3,
        SRC_RXLVL   = 4,
        SRC_TXLVL   = 5,
        SRC_RXTMO   = 6,
        SRC_FRAME   = 7,
        SRC_PARITY  = 8,
        SRC_BREAK   = 9,
        SRC_OVERRUN = 10
    } src_e;

    // Number of eighths of FIFO depth for a level code; codes above 4 act as one half.
    function automatic int unsigned level_eighths(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 7;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_level.sv
// Threshold detector for one FIFO direction.
// Raises a one-cycle event when the fill condition becomes true.
// Receive variant: occupancy at or above threshold (any data when FIFOs are off).
// Transmit variant: occupancy at or below threshold (empty when FIFOs are off).
// Assumes DEPTH is a multiple of 8.
module uart_irq_level #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter bit IS_TX = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [2:0]       code,
    input  logic [CNT_W-1:0] count,
    output logic             evt
);
    import uart_irq_pkg::*;

    localparam int STEP = DEPTH / 8;

    logic [CNT_W-1:0] thr;
    logic             cond;
    logic             cond_q;

    // Threshold in entries from the level code.
    always_comb begin
        thr = CNT_W'(STEP * level_eighths(code));
    end

    // Direction-specific fill condition.
    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                cond = fifo_en ? (count <= thr) : (count == '0);
            end
        end else begin : g_rx
            always_comb begin
                cond = fifo_en ? (count >= thr) : (count != '0);
            end
        end
    endgenerate

    // Remember the previous condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    assign evt = cond & ~cond_q;

endmodule

// File: rtl/uart_irq_status.sv
// Latched raw status word with write-one-to-clear.
// A set in the same cycle as a clear of the same bit leaves the bit set.
module uart_irq_status #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] raw
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic q;
            // Per-bit latch: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                    q <= 1'b0;
                else if (set_vec[i])           q <= 1'b1;
                else if (clr_wr && clr_bits[i]) q <= 1'b0;
            end
            assign raw[i] = q;
        end
    endgenerate

endmodule

// File: rtl/uart_irq_ctrl.sv
// Top of the UART interrupt unit: mask and level-select registers,
// cause collection, raw/masked status and the combined interrupt.
// Assumes event inputs are single-cycle pulses in the clk domain.
module uart_irq_ctrl #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                fifo_en,
    input  logic                                mask_wr,
    input  logic [uart_irq_pkg::NUM_SRC-1:0]    mask_wdata,
    input  logic                                clr_wr,
    input  logic [uart_irq_pkg::NUM_SRC-1:0]    clr_wdata,
    input  logic                                lvl_wr,
    input  logic [5:0]                          lvl_wdata,
    input  logic [3:0]                          modem_evt,
    input  logic                                rx_tmo_evt,
    input  logic [3:0]                          err_evt,
    input  logic [CNT_W-1:0]                    rx_count,
    input  logic [CNT_W-1:0]                    tx_count,
    output logic [uart_irq_pkg::NUM_SRC-1:0]    mask_q,
    output logic [5:0]                          lvl_sel,
    output logic [uart_irq_pkg::NUM_SRC-1:0]    raw_status,
    output logic [uart_irq_pkg::NUM_SRC-1:0]    masked_status,
    output logic                                irq
);
    import uart_irq_pkg::*;

    logic                rx_lvl_evt;
    logic                tx_lvl_evt;
    logic [NUM_SRC-1:0]  set_vec;

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Level-select register.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_sel <= '0;
        else if (lvl_wr) lvl_sel <= lvl_wdata;
    end

    uart_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .code    (lvl_sel[5:3]),
        .count   (rx_count),
        .evt     (rx_lvl_evt)
    );

    uart_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .code    (lvl_sel[2:0]),
        .count   (tx_count),
        .evt     (tx_lvl_evt)
    );

    // Place every cause at its status bit.
    always_comb begin
        set_vec              = '0;
        set_vec[SRC_RING]    = modem_evt[0];
        set_vec[SRC_CTS]     = modem_evt[1];
        set_vec[SRC_DCD]     = modem_evt[2];
        set_vec[SRC_DSR]     = modem_evt[3];
        set_vec[SRC_RXLVL]   = rx_lvl_evt;
        set_vec[SRC_TXLVL]   = tx_lvl_evt;
        set_vec[SRC_RXTMO]   = rx_tmo_evt;
        set_vec[SRC_FRAME]   = err_evt[0];
        set_vec[SRC_PARITY]  = err_evt[1];
        set_vec[SRC_BREAK]   = err_evt[2];
        set_vec[SRC_OVERRUN] = err_evt[3];
    end

    uart_irq_status #(.N(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (clr_wr),
        .clr_bits (clr_wdata),
        .raw      (raw_status)
    );

    // Masked view and combined interrupt.
    assign masked_status = raw_status & mask_q;
    assign irq           = |masked_status;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Property checker for uart_irq_ctrl, attached by bind.
module uart_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mask_wr,
    input logic [10:0] mask_wdata,
    input logic        clr_wr,
    input logic [10:0] clr_wdata,
    input logic        rx_tmo_evt,
    input logic [3:0]  err_evt,
    input logic [10:0] mask_q,
    input logic [10:0] raw_status,
    input logic        irq
);
    // R1
    parity_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[1] |=> raw_status[8]);

    // R2
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status[7] && !(clr_wr && clr_wdata[7]) |=> raw_status[7]);

    // R3
    frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && clr_wdata[7] && !err_evt[0] |=> !raw_status[7]);

    // R4
    tmo_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo_evt && clr_wr && clr_wdata[6] |=> raw_status[6]);

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> mask_q == $past(mask_wdata));

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == '0 |-> !irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .clr_wr     (clr_wr),
    .clr_wdata  (clr_wdata),
    .rx_tmo_evt (rx_tmo_evt),
    .err_evt    (err_evt),
    .mask_q     (mask_q),
    .raw_status (raw_status),
    .irq        (irq)
);

// File: tb/uart_irq_ctrl_test.sv
// Bench for uart_irq_ctrl: behavioural reference model compared every clock,
// plus directed scenarios with literal expectations.
module uart_irq_ctrl_test;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fifo_en;
    logic          mask_wr;
    logic [10:0]   mask_wdata;
    logic          clr_wr;
    logic [10:0]   clr_wdata;
    logic          lvl_wr;
    logic [5:0]    lvl_wdata;
    logic [3:0]    modem_evt;
    logic          rx_tmo_evt;
    logic [3:0]    err_evt;
    logic [CW-1:0] rx_count;
    logic [CW-1:0] tx_count;
    logic [10:0]   mask_q;
    logic [5:0]    lvl_sel;
    logic [10:0]   raw_status;
    logic [10:0]   masked_status;
    logic          irq;

    int vectors = 0;
    int errors  = 0;

    // Reference state.
    logic [10:0] m_raw;
    logic [10:0] m_mask;
    logic [5:0]  m_lvl;
    bit          m_rxc;
    bit          m_txc;

    always #2.5 clk = ~clk;

    uart_irq_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
        .modem_evt(modem_evt), .rx_tmo_evt(rx_tmo_evt), .err_evt(err_evt),
        .rx_count(rx_count), .tx_count(tx_count),
        .mask_q(mask_q), .lvl_sel(lvl_sel), .raw_status(raw_status),
        .masked_status(masked_status), .irq(irq)
    );

    function automatic int thresh(input int code);
        case (code)
            0: return DEPTH / 8;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            3: return (DEPTH * 3) / 4;
            4: return (DEPTH * 7) / 8;
            default: return DEPTH / 2;
        endcase
    endfunction

    task automatic model_step();
        bit rxc, txc;
        logic [10:0] setv;
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_lvl = '0; m_rxc = 0; m_txc = 0;
        end else begin
            if (fifo_en) begin
                rxc = int'(rx_count) >= thresh(int'(m_lvl[5:3]));
                txc = int'(tx_count) <= thresh(int'(m_lvl[2:0]));
            end else begin
                rxc = rx_count != 0;
                txc = tx_count == 0;
            end
            setv = {err_evt, rx_tmo_evt, (txc && !m_txc), (rxc && !m_rxc), modem_evt};
            if (clr_wr) m_raw = m_raw & ~clr_wdata;
            m_raw = m_raw | setv;
            m_rxc = rxc;
            m_txc = txc;
            if (mask_wr) m_mask = mask_wdata;
            if (lvl_wr)  m_lvl  = lvl_wdata;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1 raw", int'(raw_status), int'(m_raw));
        check("R5 mask", int'(mask_q), int'(m_mask));
        check("R5 masked", int'(masked_status), int'(m_raw & m_mask));
        check("R5 irq", int'(irq), int'(|(m_raw & m_mask)));
        check("R6 lvl", int'(lvl_sel), int'(m_lvl));
    endtask

    // One clock: model follows the edge, compare at the falling edge.
    task automatic cycle();
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        mask_wr = 0; clr_wr = 0; lvl_wr = 0;
        modem_evt = 0; rx_tmo_evt = 0; err_evt = 0;
    endtask

    task automatic do_clear(input logic [10:0] w);
        clr_wr = 1; clr_wdata = w; cycle(); clr_wr = 0;
    endtask

    initial begin
        rst_n = 0; fifo_en = 1; quiet();
        mask_wdata = 0; clr_wdata = 0; lvl_wdata = 0;
        rx_count = 0; tx_count = 5;
        @(negedge clk);
        repeat (3) cycle();
        // R11: reset state
        check("R11 raw", int'(raw_status), 0);
        check("R11 mask", int'(mask_q), 0);
        check("R11 lvl", int'(lvl_sel), 0);
        rst_n = 1;
        cycle(); cycle();

        // R1: each pulse lands on its bit
        do_clear(11'h7FF);
        modem_evt = 4'b0100; cycle(); modem_evt = 0;
        check("R1 dcd bit2", int'(raw_status), 32'h004);
        err_evt = 4'b1000; cycle(); err_evt = 0;
        check("R1 overrun bit10", int'(raw_status), 32'h404);
        rx_tmo_evt = 1; cycle(); rx_tmo_evt = 0;
        check("R1 timeout bit6", int'(raw_status), 32'h444);
        // R2: bits hold
        repeat (4) cycle();
        check("R2 hold", int'(raw_status), 32'h444);
        // R3: selective clear
        do_clear(11'h040);
        check("R3 partial", int'(raw_status), 32'h404);
        // R5: mask and irq
        mask_wr = 1; mask_wdata = 11'h400; cycle(); mask_wr = 0;
        check("R5 masked", int'(masked_status), 32'h400);
        check("R5 irq on", int'(irq), 1);
        mask_wr = 1; mask_wdata = 11'h001; cycle(); mask_wr = 0;
        check("R5 irq off", int'(irq), 0);
        // R4: same-cycle set and clear
        err_evt = 4'b0001; clr_wr = 1; clr_wdata = 11'h7FF; cycle();
        err_evt = 0; clr_wr = 0;
        check("R4 set wins", int'(raw_status), 32'h080);
        // R3: full clear
        do_clear(11'h7FF);
        check("R3 all", int'(raw_status), 0);

        // R6/R7: rx code 3 -> 12 entries, tx code 1 -> 4 entries
        lvl_wr = 1; lvl_wdata = 6'b011_001; cycle(); lvl_wr = 0;
        check("R6 readback", int'(lvl_sel), 32'h19);
        rx_count = 11; tx_count = 10; cycle(); cycle();
        do_clear(11'h7FF); cycle();
        check("R7 below", int'(raw_status[4]), 0);
        rx_count = 12; cycle();
        check("R7 reach", int'(raw_status[4]), 1);
        // R8
        check("R8 above", int'(raw_status[5]), 0);
        tx_count = 4; cycle();
        check("R8 reach", int'(raw_status[5]), 1);
        // R9: code 6 acts as 8 entries
        lvl_wr = 1; lvl_wdata = 6'b110_111; rx_count = 7; tx_count = 12; cycle(); lvl_wr = 0;
        cycle(); do_clear(11'h7FF); cycle();
        check("R9 below", int'(raw_status[4]), 0);
        rx_count = 8; cycle();
        check("R9 rx half", int'(raw_status[4]), 1);
        tx_count = 8; cycle();
        check("R9 tx half", int'(raw_status[5]), 1);
        // R10: FIFOs off
        fifo_en = 0; rx_count = 0; tx_count = 3; cycle(); cycle();
        do_clear(11'h7FF); cycle();
        check("R10 idle", int'(raw_status), 0);
        rx_count = 1; cycle();
        check("R10 rx one", int'(raw_status[4]), 1);
        tx_count = 0; cycle();
        check("R10 tx empty", int'(raw_status[5]), 1);
        fifo_en = 1;

        // Random overlapping traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            modem_evt  = ($urandom % 6 == 0) ? 4'($urandom) : 4'd0;
            err_evt    = ($urandom % 6 == 0) ? 4'($urandom) : 4'd0;
            rx_tmo_evt = ($urandom % 8 == 0);
            clr_wr     = ($urandom % 4 == 0);
            clr_wdata  = 11'($urandom);
            mask_wr    = ($urandom % 10 == 0);
            mask_wdata = 11'($urandom);
            lvl_wr     = ($urandom % 16 == 0);
            lvl_wdata  = 6'($urandom);
            rx_count   = CW'($urandom_range(0, DEPTH));
            tx_count   = CW'($urandom_range(0, DEPTH));
            if ($urandom % 50 == 0) fifo_en = ~fifo_en;
            cycle();
        end
        quiet();
        cycle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule